// File: doc/BRIEF.md
# Teletext Page Request Matcher

The matcher holds the page requests for a bank of teletext acquisition circuits and decides, for each received page header, which circuits should capture the page that follows. Each circuit owns one request record of seven 5-bit bytes. Each byte holds a do-care flag and a digit. Only the digits whose flag is set take part in the compare. This lets one record ask for a plain page number, or for a page number together with a particular time code.

Records are written through a small load port. Software sets a start column and the record address, which is a group bit plus a circuit number. It then streams bytes, and the column advances after each byte. The received header arrives already decoded, as seven digit nibbles plus one Hamming-error flag per nibble. One group of circuits is active for acquisition at a time. For every record, the block keeps a status: an active-low found flag, a looking-for-page flag, and the per-byte error flags of the header it captured. A hold bit in the magazine byte decides whether a page that was already found can be replaced.

Top module: `page_req_matcher`

## Requirements
- R1: After reset, capture is 0, found_n is all ones, looking is all zeros and rec_ham is all zeros. Every request byte is 0, which means all digits are don't-care and hold is low. The load column is parked, so req_wr pulses that come before the first ld_start are ignored.
- R2: ld_start selects record ld_group*4+ld_circ and column ld_col. Each later req_wr stores req_data into that column and then advances the column by one.
- R3: The column stops after column 6. While it is stopped, req_wr is ignored until the next ld_start. An ld_start with column 7 therefore accepts no bytes.
- R4: Request byte layout: bit 4 is the do-care flag and bits 3:0 are the digit. In byte 0, bit 3 is hold and bits 2:0 are the magazine. Byte 3 (hours tens) compares bits 1:0 only. Byte 5 (minutes tens) compares bits 2:0 only. Byte 0 compares bits 2:0 only.
- R5: Byte i of the header is hdr_digits[4i+3:4i], and its error flag is hdr_ham[i]. The order of i is magazine, page tens, page units, hours tens, hours units, minutes tens, minutes units. A cared byte hits when its compared bits are equal and its error flag is clear. A byte that is not cared always hits. A record matches when all seven bytes hit.
- R6: capture[r] is high for the single cycle after an hdr_valid cycle in which record r matches, record r is in the active group, and either its hold bit is 1 or found_n[r] is 1.
- R7: When the hold bit is 0 and found_n[r] is 0, further matching headers do not capture, so the found page is kept.
- R8: When record r captures, found_n[r] goes to 0, looking[r] goes to 0, and the row rec_ham[7r+6:7r] takes the value of hdr_ham, all in the same cycle as capture.
- R9: An accepted byte write to record r sets looking[r] to 1, found_n[r] to 1 and its rec_ham row to 0, and it blocks a capture of r in that cycle.
- R10: A record whose group (r/4) differs from acq_group never captures.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_start | input | 1 | Latch record address and start column |
| ld_group | input | 1 | Group bit of the record to load |
| ld_circ | input | 2 | Circuit number within the group |
| ld_col | input | 3 | Start column |
| req_wr | input | 1 | Write one request byte |
| req_data | input | 5 | Request byte: do-care flag and digit |
| acq_group | input | 1 | Group used for acquisition |
| hdr_valid | input | 1 | Header digits valid this cycle |
| hdr_digits | input | 28 | Seven decoded header digits, 4 bits each |
| hdr_ham | input | 7 | Per-digit Hamming error flags |
| capture | output | 8 | Per-record capture pulse |
| found_n | output | 8 | Per-record found flag, active low |
| looking | output | 8 | Per-record page-being-looked-for flag |
| rec_ham | output | 56 | Per-record captured error flags, 7 bits each |

## Verification
The bench sweeps the magazine and page-tens nibbles over all 256 values against one record, so a wrong field mask makes the hold bit or the upper nibble bits leak into the compare. A second sweep runs all 128 error-flag patterns against a fully cared record, which exposes a design that ignores the error flags or applies them to don't-care bytes. Loads that start late and overrun column 6 catch a column counter that wraps and corrupts the low columns. Long mixed runs alternate the active group, and there hold-low records fail if they recapture or are missed once found.

// File: rtl/page_req_matcher_pkg.sv
package page_req_matcher_pkg;
  localparam int NBYTE  = 7;
  localparam int BYTE_W = 5;
  localparam int DIG_W  = 4;
  localparam int REC_W  = NBYTE * BYTE_W;
  localparam int HDR_W  = NBYTE * DIG_W;

  // Bits of each digit that take part in the compare.
  function automatic logic [DIG_W-1:0] dig_mask(input int idx);
    case (idx)
      0:       return 4'b0111;   // magazine, bit 3 is hold
      3:       return 4'b0011;   // hours tens
      5:       return 4'b0111;   // minutes tens
      default: return 4'b1111;
    endcase
  endfunction

  function automatic logic byte_hit(input logic [BYTE_W-1:0] rq,
                                    input logic [DIG_W-1:0] rx,
                                    input logic err, input int idx);
    logic care;
    care = rq[BYTE_W-1];
    return !care || (!err && (((rq[DIG_W-1:0] ^ rx) & dig_mask(idx)) == '0));
  endfunction

  function automatic logic rec_hit(input logic [REC_W-1:0] rq,
                                   input logic [HDR_W-1:0] dg,
                                   input logic [NBYTE-1:0] ham);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < NBYTE; i++)
      ok = ok & byte_hit(rq[i*BYTE_W +: BYTE_W], dg[i*DIG_W +: DIG_W], ham[i], i);
    return ok;
  endfunction
endpackage

// File: rtl/pmr_req_store.sv
module pmr_req_store
  import page_req_matcher_pkg::*;
#(
  parameter int NREC = 8,
  localparam int RA_W = (NREC > 1) ? $clog2(NREC) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ld_start,
  input  logic [RA_W-1:0]         ld_rec,
  input  logic [2:0]              ld_col,
  input  logic                    req_wr,
  input  logic [BYTE_W-1:0]       req_data,
  output logic [NREC*REC_W-1:0]   req_flat,
  output logic                    wr_accept,
  output logic [RA_W-1:0]         wr_rec
);
  localparam logic [2:0] COL_PARK = 3'd7;

  logic [2:0]      col_q;
  logic [RA_W-1:0] rec_q;

  assign wr_accept = req_wr && !ld_start && (col_q != COL_PARK);
  assign wr_rec    = rec_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col_q <= COL_PARK;
      rec_q <= '0;
    end else if (ld_start) begin
      col_q <= ld_col;
      rec_q <= ld_rec;
    end else if (wr_accept) begin
      col_q <= col_q + 3'd1;   // column 6 steps into the parked state
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      req_flat <= '0;
    else if (wr_accept)
      req_flat[(int'(rec_q) * NBYTE + int'(col_q)) * BYTE_W +: BYTE_W] <= req_data;
  end
endmodule

// File: rtl/pmr_match.sv
module pmr_match
  import page_req_matcher_pkg::*;
#(
  parameter int NREC = 8,
  parameter int CIRC = 4,
  localparam int NGRP = NREC / CIRC,
  localparam int GRP_W = (NGRP > 1) ? $clog2(NGRP) : 1
) (
  input  logic [NREC*REC_W-1:0] req_flat,
  input  logic [GRP_W-1:0]      acq_group,
  input  logic [HDR_W-1:0]      hdr_digits,
  input  logic [NBYTE-1:0]      hdr_ham,
  output logic [NREC-1:0]       hit
);
  for (genvar r = 0; r < NREC; r++) begin : g_rec
    localparam int G = r / CIRC;
    logic in_group;
    assign in_group = (int'(acq_group) == G);
    assign hit[r] = in_group && rec_hit(req_flat[r*REC_W +: REC_W], hdr_digits, hdr_ham);
  end
endmodule

// File: rtl/pmr_status.sv
module pmr_status
  import page_req_matcher_pkg::*;
#(
  parameter int NREC = 8,
  localparam int RA_W = (NREC > 1) ? $clog2(NREC) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  hdr_valid,
  input  logic [NBYTE-1:0]      hdr_ham,
  input  logic [NREC-1:0]       hit,
  input  logic [NREC-1:0]       hold_vec,
  input  logic                  wr_accept,
  input  logic [RA_W-1:0]       wr_rec,
  output logic [NREC-1:0]       capture,
  output logic [NREC-1:0]       found_n,
  output logic [NREC-1:0]       looking,
  output logic [NREC*NBYTE-1:0] rec_ham
);
  for (genvar r = 0; r < NREC; r++) begin : g_rec
    logic reopen, take;
    assign reopen = wr_accept && (int'(wr_rec) == r);
    assign take   = hdr_valid && hit[r] && (hold_vec[r] || found_n[r]) && !reopen;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        capture[r]                 <= 1'b0;
        found_n[r]                 <= 1'b1;
        looking[r]                 <= 1'b0;
        rec_ham[r*NBYTE +: NBYTE]  <= '0;
      end else begin
        capture[r] <= take;
        if (reopen) begin
          found_n[r]                <= 1'b1;
          looking[r]                <= 1'b1;
          rec_ham[r*NBYTE +: NBYTE] <= '0;
        end else if (take) begin
          found_n[r]                <= 1'b0;
          looking[r]                <= 1'b0;
          rec_ham[r*NBYTE +: NBYTE] <= hdr_ham;
        end
      end
    end
  end
endmodule

// File: rtl/page_req_matcher.sv
module page_req_matcher
  import page_req_matcher_pkg::*;
#(
  parameter int CIRC_PER_GROUP = 4,
  parameter int GROUPS         = 2,
  localparam int NREC  = CIRC_PER_GROUP * GROUPS,
  localparam int CIRC_W = (CIRC_PER_GROUP > 1) ? $clog2(CIRC_PER_GROUP) : 1,
  localparam int GRP_W  = (GROUPS > 1) ? $clog2(GROUPS) : 1,
  localparam int RA_W   = (NREC > 1) ? $clog2(NREC) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ld_start,
  input  logic [GRP_W-1:0]        ld_group,
  input  logic [CIRC_W-1:0]       ld_circ,
  input  logic [2:0]              ld_col,
  input  logic                    req_wr,
  input  logic [BYTE_W-1:0]       req_data,
  input  logic [GRP_W-1:0]        acq_group,
  input  logic                    hdr_valid,
  input  logic [HDR_W-1:0]        hdr_digits,
  input  logic [NBYTE-1:0]        hdr_ham,
  output logic [NREC-1:0]         capture,
  output logic [NREC-1:0]         found_n,
  output logic [NREC-1:0]         looking,
  output logic [NREC*NBYTE-1:0]   rec_ham
);
  logic [NREC*REC_W-1:0] req_flat;
  logic [RA_W-1:0]       ld_rec;
  logic                  wr_accept;
  logic [RA_W-1:0]       wr_rec;
  logic [NREC-1:0]       hit;
  logic [NREC-1:0]       hold_vec;

  assign ld_rec = RA_W'(int'(ld_group) * CIRC_PER_GROUP + int'(ld_circ));

  for (genvar r = 0; r < NREC; r++) begin : g_hold
    assign hold_vec[r] = req_flat[r*REC_W + 3];
  end

  pmr_req_store #(.NREC(NREC)) u_store (
    .clk(clk), .rst_n(rst_n), .ld_start(ld_start), .ld_rec(ld_rec),
    .ld_col(ld_col), .req_wr(req_wr), .req_data(req_data),
    .req_flat(req_flat), .wr_accept(wr_accept), .wr_rec(wr_rec)
  );

  pmr_match #(.NREC(NREC), .CIRC(CIRC_PER_GROUP)) u_match (
    .req_flat(req_flat), .acq_group(acq_group), .hdr_digits(hdr_digits),
    .hdr_ham(hdr_ham), .hit(hit)
  );

  pmr_status #(.NREC(NREC)) u_status (
    .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_ham(hdr_ham),
    .hit(hit), .hold_vec(hold_vec), .wr_accept(wr_accept), .wr_rec(wr_rec),
    .capture(capture), .found_n(found_n), .looking(looking), .rec_ham(rec_ham)
  );
endmodule

// File: rtl/page_req_matcher_checker.sv
module page_req_matcher_checker #(
  parameter int NREC  = 8,
  parameter int CIRC  = 4,
  parameter int GRP_W = 1,
  parameter int RA_W  = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hdr_valid,
  input logic [GRP_W-1:0] acq_group,
  input logic [NREC-1:0]  capture,
  input logic [NREC-1:0]  found_n,
  input logic [NREC-1:0]  looking,
  input logic [NREC-1:0]  hold_vec,
  input logic             wr_accept,
  input logic [RA_W-1:0]  wr_rec
);
  a_r6_capture_follows_header: assert property (@(posedge clk) disable iff (!rst_n)
    (|capture) |-> $past(hdr_valid));

  for (genvar r = 0; r < NREC; r++) begin : g_rec
    localparam int G = r / CIRC;

    a_r8_capture_marks_found: assert property (@(posedge clk) disable iff (!rst_n)
      capture[r] |-> (!found_n[r] && !looking[r]));

    a_r7_hold_keeps_page: assert property (@(posedge clk) disable iff (!rst_n)
      capture[r] |-> ($past(found_n[r]) || $past(hold_vec[r])));

    a_r10_group_gate: assert property (@(posedge clk) disable iff (!rst_n)
      capture[r] |-> (int'($past(acq_group)) == G));

    a_r9_write_reopens: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_accept && int'(wr_rec) == r) |=> (looking[r] && found_n[r] && !capture[r]));
  end
endmodule

bind page_req_matcher page_req_matcher_checker #(
  .NREC(NREC), .CIRC(CIRC_PER_GROUP), .GRP_W(GRP_W), .RA_W(RA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .acq_group(acq_group),
  .capture(capture), .found_n(found_n), .looking(looking),
  .hold_vec(hold_vec), .wr_accept(wr_accept), .wr_rec(wr_rec)
);

// File: tb/page_req_matcher_test.sv
module page_req_matcher_test;
  localparam int CLK_PERIOD = 10;
  localparam int NR = 8;

  logic clk = 0, rst_n = 0;
  logic ld_start = 0, ld_group = 0, req_wr = 0, acq_group = 0, hdr_valid = 0;
  logic [1:0] ld_circ = 0;
  logic [2:0] ld_col = 0;
  logic [4:0] req_data = 0;
  logic [27:0] hdr_digits = 0;
  logic [6:0] hdr_ham = 0;
  logic [7:0] capture, found_n, looking;
  logic [55:0] rec_ham;

  int checks = 0, failures = 0;
  string tag = "R1";

  // bench model
  logic [4:0] m_req [NR][7];
  logic [7:0] m_found_n, m_looking;
  logic [6:0] m_ham [NR];

  always #(CLK_PERIOD/2) clk = ~clk;

  page_req_matcher uut (
    .clk(clk), .rst_n(rst_n), .ld_start(ld_start), .ld_group(ld_group),
    .ld_circ(ld_circ), .ld_col(ld_col), .req_wr(req_wr), .req_data(req_data),
    .acq_group(acq_group), .hdr_valid(hdr_valid), .hdr_digits(hdr_digits),
    .hdr_ham(hdr_ham), .capture(capture), .found_n(found_n),
    .looking(looking), .rec_ham(rec_ham)
  );

  task automatic check(input string what, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s got=%h exp=%h", tag, what, got, exp);
    end
  endtask

  function automatic int fwidth(input int i);
    return (i == 3) ? 2 : ((i == 0 || i == 5) ? 3 : 4);
  endfunction

  function automatic bit m_hit(input int r, input logic [27:0] d, input logic [6:0] h);
    for (int i = 0; i < 7; i++) begin
      int span, a, b;
      span = 1 << fwidth(i);
      a = int'(m_req[r][i][3:0]) % span;
      b = int'(d[i*4 +: 4]) % span;
      if (m_req[r][i][4] && (h[i] || a != b)) return 0;
    end
    return 1;
  endfunction

  task automatic check_flags();
    logic [55:0] eh;
    for (int r = 0; r < NR; r++) eh[r*7 +: 7] = m_ham[r];
    check("found_n", 64'(found_n), 64'(m_found_n));
    check("looking", 64'(looking), 64'(m_looking));
    check("rec_ham", 64'(rec_ham), 64'(eh));
  endtask

  // start column col, then n bytes; values from f(seed, k)
  task automatic do_load(input int rec, input int col, input int n, input int seed);
    int p;
    @(negedge clk);
    ld_start = 1; ld_group = rec[2]; ld_circ = rec[1:0]; ld_col = col[2:0];
    @(negedge clk);
    ld_start = 0;
    p = col;
    for (int k = 0; k < n; k++) begin
      logic [4:0] v;
      int j;
      j = p % 8;
      v[4] = ((rec + j + seed) % 4) != 0;
      v[3:0] = 4'((rec * 3 + j * 5 + seed) % 10);
      if (j == 0) v[3:0] = {1'((rec + seed) % 2), 3'((rec + seed + k) % 8)};
      req_wr = 1; req_data = v;
      if (p < 7) begin
        m_req[rec][p] = v; m_looking[rec] = 1; m_found_n[rec] = 1; m_ham[rec] = 0;
        p++;
      end
      @(negedge clk);
    end
    req_wr = 0;
    @(negedge clk);
  endtask

  task automatic load_bytes(input int rec, input logic [4:0] b [7]);
    @(negedge clk);
    ld_start = 1; ld_group = rec[2]; ld_circ = rec[1:0]; ld_col = 0;
    @(negedge clk);
    ld_start = 0;
    for (int k = 0; k < 7; k++) begin
      req_wr = 1; req_data = b[k]; m_req[rec][k] = b[k];
      m_looking[rec] = 1; m_found_n[rec] = 1; m_ham[rec] = 0;
      @(negedge clk);
    end
    req_wr = 0;
    @(negedge clk);
  endtask

  task automatic do_hdr(input logic [27:0] d, input logic [6:0] h);
    logic [7:0] ecap;
    hdr_valid = 1; hdr_digits = d; hdr_ham = h;
    ecap = 0;
    for (int r = 0; r < NR; r++)
      if ((r / 4) == int'(acq_group) && m_hit(r, d, h) &&
          (m_req[r][0][3] || m_found_n[r])) ecap[r] = 1;
    @(negedge clk);
    hdr_valid = 0;
    for (int r = 0; r < NR; r++)
      if (ecap[r]) begin m_found_n[r] = 0; m_looking[r] = 0; m_ham[r] = h; end
    check("capture", 64'(capture), 64'(ecap));
    check_flags();
  endtask

  function automatic logic [27:0] hdr_of(input int r);
    logic [27:0] d;
    for (int i = 0; i < 7; i++) d[i*4 +: 4] = m_req[r][i][3:0];
    return d;
  endfunction

  initial begin
    for (int r = 0; r < NR; r++) begin
      for (int i = 0; i < 7; i++) m_req[r][i] = 0;
      m_ham[r] = 0;
    end
    m_found_n = '1; m_looking = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    tag = "R1";
    check("capture", 64'(capture), 64'h0);
    check_flags();
    // R1: writes before any load are ignored (model ignores them)
    for (int k = 0; k < 3; k++) begin req_wr = 1; req_data = 5'h1F; @(negedge clk); end
    req_wr = 0;
    @(negedge clk);
    check_flags();
    do_hdr(28'h0, 7'h0);                 // all don't-care: group 0 captures
    do_hdr(28'h0, 7'h0);                 // R7: hold low, no recapture

    // R2 R3: full loads, some late starts overrunning column 6
    tag = "R2 R3";
    for (int r = 0; r < NR; r++) do_load(r, (r % 3 == 2) ? 3 : 0, 9, 1);
    check_flags();
    do_load(6, 7, 4, 9);                 // R3: column 7, nothing taken
    check_flags();
    for (int r = 0; r < NR; r++) begin
      acq_group = r[2];
      do_hdr(hdr_of(r), 7'h0);
    end

    // R4 R5: magazine x page-tens sweep against record 0
    tag = "R4 R5";
    acq_group = 0;
    begin
      logic [4:0] b [7];
      b[0] = 5'b1_1_101; b[1] = 5'b1_0111;
      for (int i = 2; i < 7; i++) b[i] = 5'b0_1001;
      load_bytes(0, b);
      for (int m = 0; m < 16; m++)
        for (int t = 0; t < 16; t++)
          do_hdr({20'h12345, 4'(t), 4'(m)}, 7'h0);
      // R4: narrow fields; R5: every error pattern against a fully cared record
      b[0] = 5'b1_1_010; b[1] = 5'b1_0011; b[2] = 5'b1_0100; b[3] = 5'b1_1110;
      b[4] = 5'b1_0110; b[5] = 5'b1_1101; b[6] = 5'b1_1000;
      load_bytes(1, b);
      for (int e = 0; e < 128; e++)
        do_hdr({4'h8, 4'h5, 4'h6, 4'h2, 4'h4, 4'h3, 4'hA}, 7'(e));
    end

    // R6 R7 R8 R9 R10: mixed run with group switching and periodic reloads
    tag = "R6 R7 R8 R10";
    for (int n = 0; n < 480; n++) begin
      logic [27:0] d;
      logic [6:0] h;
      int k;
      if (n % 48 == 0) begin
        tag = "R9";
        for (int r = 0; r < NR; r++) do_load(r, ((r + n) % 5 == 4) ? 3 : 0, 8, n / 48);
        check_flags();
        tag = "R6 R7 R8 R10";
      end
      acq_group = 1'((n / 24) % 2);
      k = n % 8;
      d = hdr_of(k);
      h = 0;
      if (n % 3 == 1) d[((n / 3) % 7) * 4] = ~d[((n / 3) % 7) * 4];
      if (n % 5 == 2) h[(n / 5) % 7] = 1;
      do_hdr(d, h);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule